// File: doc/BRIEF.md
# PHY Link and Media Sense Sequencer

This block decides how an Ethernet MAC should run by talking to its PHY over the two-wire management bus. A one-cycle `start` pulse begins a fixed sequence. The block first raises the store-and-forward mode bit. On a 10 Mb/s-only part, it forces the PHY control register to zero and ends there. On other parts, it polls the PHY status until the link is up or a timeout elapses. If the link comes up, it reads the duplex result. If the link does not come up, it selects the alternate home-network PHY instead.

When the alternate PHY is selected, the block identifies that PHY. If the PHY belongs to the expected family, the block programs two of its configuration registers, using values that depend on the identifier words it reads back. All management traffic goes to PHY address 1. Each frame starts with a 34-bit preamble. The block ends the sequence with a one-cycle `done` pulse. The mode outputs then hold their values until the next `start`.

The states of the sequencer and the moves between them are:

- SQ_IDLE goes to SQ_MODE on `start`.
- SQ_MODE goes to SQ_FORCE10 when `ten_only` is high, and to SQ_POLL otherwise.
- SQ_FORCE10 goes to SQ_DONE.
- SQ_POLL repeats itself. It goes to SQ_DUPLEX when the link is up, and to SQ_ID_LO once the timeout has expired.
- SQ_DUPLEX goes to SQ_DONE.
- SQ_ID_LO goes to SQ_ID_HI on a family match, and to SQ_DONE otherwise.
- SQ_ID_HI goes to SQ_CFG16.
- SQ_CFG16 goes to SQ_RD24 for the first family member, and to SQ_RD25 otherwise.
- SQ_RD24 and SQ_RD25 both go to SQ_CFG25.
- SQ_CFG25 goes to SQ_DONE.
- SQ_DONE goes to SQ_IDLE.

Every state except SQ_IDLE, SQ_MODE and SQ_DONE waits for the end of its management frame before it moves on.

The frame engine has three states: MF_IDLE, MF_LOW (clock low, data presented) and MF_HIGH (clock high).

Top module: `phy_media_seq`

## Requirements
- R1: Every management frame has the following layout:
  - 34 one bits;
  - the start pattern 0,1;
  - the opcode, 1,0 for a read and 0,1 for a write;
  - the PHY address 1 as 5 bits, MSB first;
  - the register address as 5 bits, MSB first.
- R2: On a read, the data line is released (`mdio_oe` low) for one turnaround bit and then for 16 data bits. The data bits are sampled MSB first, at the rising edge of `mdc`.
- R3: On a write, the turnaround bits 1,0 are driven, then the 16 data bits, MSB first.
- R4: `mdio_o` and `mdio_oe` change only while `mdc` is low. `mdc` and `mdio_oe` are low whenever the block is not busy.
- R5: `start` in idle sets `store_fwd` and clears `full_duplex` and `alt_phy_sel`. After reset, all three mode bits are 0.
- R6: With `ten_only` high, the only frame is a write of 0x0000 to register 0. Register 1 is not read, and `full_duplex` and `alt_phy_sel` stay 0.
- R7: Otherwise, register 1 is read repeatedly until bits 2 and 5 are both set. If that has not happened and LINK_TIMEOUT cycles have passed since polling began, `alt_phy_sel` is set. Polling never ends early through the timeout path.
- R8: When the link is up, register 17 is read. `full_duplex` is set exactly when bit 15 or bit 13 of that value is 1.
- R9: With the alternate PHY selected, register 3 is read. If (value AND 0xFFF0) is not 0xB900, no write is issued.
- R10: If the family matches and register 31 reads 0x4404, the block does two things:
  - It writes register 16 with 0x0005 if register 3 was 0xB901, and with 0x1005 otherwise.
  - It reads register 24 and writes register 25 with ((value + 3) AND 0x00FF) OR 0xF000.
- R11: If the family matches and register 31 is any other value, the block writes register 16 with 0x0005. It then reads register 25 and writes it back as (value AND 0xFF00) + 2.
- R12: `done` is high for exactly one cycle at the end of each sequence. A `start` while busy is ignored. The mode bits hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a sequence when idle |
| ten_only | input | 1 | Part is the 10 Mb/s-only variant (latched at start) |
| mdio_i | input | 1 | Management data from the PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven to the PHY |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| store_fwd | output | 1 | Store-and-forward mode bit |
| full_duplex | output | 1 | Full-duplex mode bit |
| alt_phy_sel | output | 1 | Alternate home-network PHY select |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A wrong sequencer state shows up on the management bus within one frame. It appears as a write to the wrong register, a wrong data word, or a frame that should not be there. A PHY model in the bench decodes every frame and checks it against the expected write list. A wrong bit counter or a wrong clock phase breaks the preamble length, the address field or the turnaround pattern of the next frame, and these are checked bit by bit. A wrong duplex or timeout decision shows up on the mode bits in the same cycle as `done`. An early timeout shows up as a sequence that finishes too soon.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_MODE,
        SQ_FORCE10,
        SQ_POLL,
        SQ_DUPLEX,
        SQ_ID_LO,
        SQ_ID_HI,
        SQ_CFG16,
        SQ_RD24,
        SQ_RD25,
        SQ_CFG25,
        SQ_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        MF_IDLE,
        MF_LOW,
        MF_HIGH
    } mf_state_t;

    localparam logic [4:0] RA_CTRL   = 5'd0;
    localparam logic [4:0] RA_STAT   = 5'd1;
    localparam logic [4:0] RA_IDLO   = 5'd3;
    localparam logic [4:0] RA_CFG16  = 5'd16;
    localparam logic [4:0] RA_DUPX   = 5'd17;
    localparam logic [4:0] RA_R24    = 5'd24;
    localparam logic [4:0] RA_R25    = 5'd25;
    localparam logic [4:0] RA_VENDOR = 5'd31;

    localparam logic [15:0] FAMILY_MASK = 16'hFFF0;
    localparam logic [15:0] FAMILY_ID   = 16'hB900;
    localparam logic [15:0] REV_E4_ID   = 16'hB901;
    localparam logic [15:0] VENDOR_A    = 16'h4404;

endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import phy_seq_pkg::*;
#(
    parameter int         DIV      = 2,
    parameter int         PRE_LEN  = 34,
    parameter logic [4:0] PHY_ADDR = 5'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        wr,
    input  logic [4:0]  ra,
    input  logic [15:0] wd,
    input  logic        mdio_i,
    output logic        ack,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);

    localparam int IDXW = $clog2(PRE_LEN + 33);
    localparam int DW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [IDXW-1:0] PRE_END = IDXW'(PRE_LEN);
    localparam logic [IDXW-1:0] TA_IDX  = IDXW'(PRE_LEN + 14);
    localparam logic [IDXW-1:0] RD_LAST = IDXW'(PRE_LEN + 30);
    localparam logic [IDXW-1:0] WR_LAST = IDXW'(PRE_LEN + 31);
    localparam logic [DW-1:0]   DCNT_MAX = DW'(DIV - 1);

    mf_state_t       st;
    logic [IDXW-1:0] idx;
    logic [DW-1:0]   dcnt;
    logic [31:0]     sh;
    logic            wr_q;
    logic [IDXW-1:0] last_idx;

    assign last_idx = wr_q ? WR_LAST : RD_LAST;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= MF_IDLE;
            idx   <= '0;
            dcnt  <= '0;
            sh    <= '0;
            wr_q  <= 1'b0;
            rdata <= '0;
        end else begin
            unique case (st)
                MF_IDLE: begin
                    if (req) begin
                        st   <= MF_LOW;
                        idx  <= '0;
                        dcnt <= '0;
                        wr_q <= wr;
                        sh   <= {2'b01, (wr ? 2'b01 : 2'b10), PHY_ADDR, ra, 2'b10, wd};
                    end
                end
                MF_LOW: begin
                    if (dcnt == DCNT_MAX) begin
                        dcnt <= '0;
                        st   <= MF_HIGH;
                        if (!wr_q && idx > TA_IDX)
                            rdata <= {rdata[14:0], mdio_i};
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
                MF_HIGH: begin
                    if (dcnt == DCNT_MAX) begin
                        dcnt <= '0;
                        if (idx >= PRE_END)
                            sh <= {sh[30:0], 1'b0};
                        if (idx == last_idx) begin
                            st <= MF_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= MF_LOW;
                        end
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
                default: st <= MF_IDLE;
            endcase
        end
    end

    always_comb begin
        mdc     = (st == MF_HIGH);
        mdio_oe = (st != MF_IDLE) && (wr_q || idx < TA_IDX);
        mdio_o  = mdio_oe && ((idx < PRE_END) || sh[31]);
        ack     = (st == MF_HIGH) && (dcnt == DCNT_MAX) && (idx == last_idx);
    end

endmodule

// File: rtl/link_timer.sv
module link_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);

    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LIM = TW'(LIMIT);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (run && cnt < LIM)
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt >= LIM);

endmodule

// File: rtl/phy_media_seq.sv
module phy_media_seq
    import phy_seq_pkg::*;
#(
    parameter int         MDC_HALF     = 25,
    parameter int         LINK_TIMEOUT = 250_000_000,
    parameter logic [4:0] PHY_ADDR     = 5'd1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ten_only,
    input  logic mdio_i,
    output logic mdc,
    output logic mdio_o,
    output logic mdio_oe,
    output logic store_fwd,
    output logic full_duplex,
    output logic alt_phy_sel,
    output logic busy,
    output logic done
);

    seq_state_t  st, st_nx;
    logic        ten_q, fam_a;
    logic [15:0] id_q, hold_q;
    logic        req, wr, ack, expired;
    logic [4:0]  ra;
    logic [15:0] wd, rdata;
    logic        link_ok, fam_hit;

    mdio_frame_engine #(.DIV(MDC_HALF), .PRE_LEN(34), .PHY_ADDR(PHY_ADDR)) u_mf (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .ra(ra), .wd(wd),
        .mdio_i(mdio_i), .ack(ack), .rdata(rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    link_timer #(.LIMIT(LINK_TIMEOUT)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .clear(st == SQ_MODE), .run(st == SQ_POLL), .expired(expired)
    );

    assign link_ok = rdata[2] && rdata[5];
    assign fam_hit = (rdata & FAMILY_MASK) == FAMILY_ID;

    always_comb begin
        st_nx = st;
        unique case (st)
            SQ_IDLE:    if (start) st_nx = SQ_MODE;
            SQ_MODE:    st_nx = ten_q ? SQ_FORCE10 : SQ_POLL;
            SQ_FORCE10: if (ack) st_nx = SQ_DONE;
            SQ_POLL:    if (ack) begin
                            if (link_ok)      st_nx = SQ_DUPLEX;
                            else if (expired) st_nx = SQ_ID_LO;
                        end
            SQ_DUPLEX:  if (ack) st_nx = SQ_DONE;
            SQ_ID_LO:   if (ack) st_nx = fam_hit ? SQ_ID_HI : SQ_DONE;
            SQ_ID_HI:   if (ack) st_nx = SQ_CFG16;
            SQ_CFG16:   if (ack) st_nx = fam_a ? SQ_RD24 : SQ_RD25;
            SQ_RD24:    if (ack) st_nx = SQ_CFG25;
            SQ_RD25:    if (ack) st_nx = SQ_CFG25;
            SQ_CFG25:   if (ack) st_nx = SQ_DONE;
            SQ_DONE:    st_nx = SQ_IDLE;
            default:    st_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= SQ_IDLE;
            ten_q       <= 1'b0;
            fam_a       <= 1'b0;
            id_q        <= '0;
            hold_q      <= '0;
            store_fwd   <= 1'b0;
            full_duplex <= 1'b0;
            alt_phy_sel <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == SQ_IDLE && start) begin
                ten_q       <= ten_only;
                store_fwd   <= 1'b1;
                full_duplex <= 1'b0;
                alt_phy_sel <= 1'b0;
            end
            if (ack) begin
                unique case (st)
                    SQ_POLL:          if (!link_ok && expired) alt_phy_sel <= 1'b1;
                    SQ_DUPLEX:        full_duplex <= rdata[15] | rdata[13];
                    SQ_ID_LO:         id_q <= rdata;
                    SQ_ID_HI:         fam_a <= (rdata == VENDOR_A);
                    SQ_RD24, SQ_RD25: hold_q <= rdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        req  = 1'b1;
        wr   = 1'b0;
        ra   = RA_STAT;
        wd   = 16'h0000;
        busy = (st != SQ_IDLE);
        done = (st == SQ_DONE);
        unique case (st)
            SQ_FORCE10: begin wr = 1'b1; ra = RA_CTRL; end
            SQ_POLL:    ra = RA_STAT;
            SQ_DUPLEX:  ra = RA_DUPX;
            SQ_ID_LO:   ra = RA_IDLO;
            SQ_ID_HI:   ra = RA_VENDOR;
            SQ_CFG16: begin
                wr = 1'b1;
                ra = RA_CFG16;
                wd = (fam_a && id_q != REV_E4_ID) ? 16'h1005 : 16'h0005;
            end
            SQ_RD24:    ra = RA_R24;
            SQ_RD25:    ra = RA_R25;
            SQ_CFG25: begin
                wr = 1'b1;
                ra = RA_R25;
                wd = fam_a ? (((hold_q + 16'd3) & 16'h00FF) | 16'hF000)
                           : ((hold_q & 16'hFF00) + 16'd2);
            end
            default:    req = 1'b0;
        endcase
    end

endmodule

// File: rtl/phy_media_seq_chk.sv
module phy_media_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic store_fwd,
    input logic full_duplex,
    input logic alt_phy_sel
);

    AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe))); // R4

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R4

    AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_duplex && alt_phy_sel)); // R7

    AST_SF_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> store_fwd); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

    AST_MODES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({store_fwd, full_duplex, alt_phy_sel})); // R12

endmodule

bind phy_media_seq phy_media_seq_chk u_chk (.*);

// File: tb/sim_phy_media_seq.sv
module sim_phy_media_seq;

    localparam int HALF = 2;
    localparam int TMO  = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ten_only = 1'b0;
    logic phy_mdo = 1'b1;
    logic mdc, mdio_o, mdio_oe, store_fwd, full_duplex, alt_phy_sel, busy, done;

    always #4 clk = ~clk;

    phy_media_seq #(.MDC_HALF(HALF), .LINK_TIMEOUT(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ten_only(ten_only),
        .mdio_i(phy_mdo), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .store_fwd(store_fwd), .full_duplex(full_duplex),
        .alt_phy_sel(alt_phy_sel), .busy(busy), .done(done)
    );

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic [4:0]  ra;
        logic [15:0] d;
    } wr_t;
    wr_t exp_q[$];

    logic [15:0] regs [32];
    logic [15:0] r1_down, r1_up;
    int link_after, r1_base;

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // PHY model and write monitor
    int ones = 0, pos = 0, rd_left = 0, r1_reads = 0;
    bit in_fr = 0, rd_act = 0;
    logic [11:0] hdr = '0;
    logic [17:0] wsh = '0;
    logic [15:0] rd_val = '0;

    always @(posedge mdc or negedge mdc) begin
        if (mdc) begin
            if (rd_act) begin
                chk("R2", "line released in read", {31'd0, mdio_oe}, 0);
                if (rd_left == 0) begin rd_act = 0; ones = 0; end
            end else if (!in_fr) begin
                if (mdio_oe && mdio_o) ones++;
                else if (mdio_oe) begin
                    if (ones >= 32) begin
                        chk("R1", "preamble ones", ones, 34);
                        in_fr = 1; pos = 0;
                    end
                    ones = 0;
                end
            end else begin
                pos++;
                if (pos == 1) chk("R1", "start second bit", {31'd0, mdio_o}, 1);
                else if (pos <= 13) hdr = {hdr[10:0], mdio_o};
                else wsh = {wsh[16:0], mdio_o};
                if (pos == 13) begin
                    chk("R1", "phy address", {27'd0, hdr[9:5]}, 1);
                    if (hdr[11:10] == 2'b10) begin
                        rd_act = 1; rd_left = 17; in_fr = 0;
                        if (hdr[4:0] == 5'd1) begin
                            r1_reads++;
                            rd_val = (r1_reads - r1_base >= link_after) ? r1_up : r1_down;
                        end else begin
                            rd_val = regs[hdr[4:0]];
                        end
                    end else begin
                        chk("R1", "write opcode", {30'd0, hdr[11:10]}, 1);
                    end
                end
                if (pos == 31) begin
                    in_fr = 0; ones = 0;
                    chk("R3", "write turnaround", {30'd0, wsh[17:16]}, 2);
                    if (exp_q.size() == 0) begin
                        chk("R9", "unexpected write reg", {27'd0, hdr[4:0]}, 32'hFFFF_FFFF);
                    end else begin
                        wr_t e;
                        e = exp_q.pop_front();
                        chk("R10", "write register", {27'd0, hdr[4:0]}, {27'd0, e.ra});
                        chk("R11", "write data", {16'd0, wsh[15:0]}, {16'd0, e.d});
                    end
                end
            end
        end else begin
            if (rd_act && rd_left > 0) begin
                phy_mdo = (rd_left == 17) ? 1'b0 : rd_val[rd_left-1];
                rd_left--;
            end else begin
                phy_mdo = 1'b1;
            end
        end
    end

    // R4: data and enable hold while the clock is high
    logic prev_mdc = 0, prev_o = 0, prev_oe = 0;
    always @(negedge clk) begin
        if (rst_n && mdc && prev_mdc)
            chk("R4", "data steady while clock high", {30'd0, mdio_o, mdio_oe}, {30'd0, prev_o, prev_oe});
        prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
    end

    task automatic run_case(input bit ten, input int lk,
                            input logic [15:0] r1d, r1u, r17, r3, r31, r24, r25,
                            input bit mid, output int cyc);
        regs[17] = r17; regs[3] = r3; regs[31] = r31; regs[24] = r24; regs[25] = r25;
        r1_down = r1d; r1_up = r1u; link_after = lk; r1_base = r1_reads;
        @(negedge clk);
        ten_only = ten; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            start = (mid && cyc == 40);
        end
        start = 1'b0;
        chk("R12", "sequence reached done", {31'd0, done}, 1);
    endtask

    task automatic chk_modes(input string rq, input bit fd, input bit alt);
        chk("R5", "store_fwd", {31'd0, store_fwd}, 1);
        chk(rq, "full_duplex", {31'd0, full_duplex}, {31'd0, fd});
        chk(rq, "alt_phy_sel", {31'd0, alt_phy_sel}, {31'd0, alt});
        chk(rq, "writes outstanding", exp_q.size(), 0);
        @(negedge clk);
        chk("R12", "done lasts one cycle", {31'd0, done}, 0);
    endtask

    initial begin
        int cyc;
        for (int i = 0; i < 32; i++) regs[i] = 16'h0000;
        r1_down = 0; r1_up = 0; link_after = 1; r1_base = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5", "reset store_fwd", {31'd0, store_fwd}, 0);
        chk("R5", "reset full_duplex", {31'd0, full_duplex}, 0);
        chk("R5", "reset alt_phy_sel", {31'd0, alt_phy_sel}, 0);
        chk("R4", "reset mdc", {31'd0, mdc}, 0);
        chk("R4", "reset mdio_oe", {31'd0, mdio_oe}, 0);
        chk("R12", "reset busy/done", {30'd0, busy, done}, 0);

        // R6: 10 Mb/s-only part
        exp_q.push_back('{5'd0, 16'h0000});
        run_case(1, 1, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 0, cyc);
        chk("R6", "no status polls", r1_reads - r1_base, 0);
        chk_modes("R6", 0, 0);

        // R7/R8: link after three polls, bit 15 duplex
        run_case(0, 3, 16'h0000, 16'h782D, 16'h8000, 16'h0, 16'h0, 16'h0, 16'h0, 0, cyc);
        chk("R7", "status polls until link", r1_reads - r1_base, 3);
        chk_modes("R8", 1, 0);

        // R8: bit 13 alone gives full duplex
        run_case(0, 1, 16'h0000, 16'h0024, 16'h2000, 16'h0, 16'h0, 16'h0, 16'h0, 0, cyc);
        chk_modes("R8", 1, 0);

        // R8: bits 14 and 12 only give half duplex
        run_case(0, 1, 16'h0000, 16'h0024, 16'h5FFF, 16'h0, 16'h0, 16'h0, 16'h0, 0, cyc);
        chk_modes("R8", 0, 0);

        // R7/R9: only bit 2 set, never links, foreign identifier
        run_case(0, 1000000, 16'h0004, 16'h0024, 16'h0, 16'h1234, 16'h0, 16'h0, 16'h0, 0, cyc);
        chk("R7", "timeout not before limit", {31'd0, cyc >= TMO}, 1);
        chk_modes("R9", 0, 1);

        // R10: vendor A, revision E4
        exp_q.push_back('{5'd16, 16'h0005});
        exp_q.push_back('{5'd25, 16'hF001});
        run_case(0, 1000000, 16'h0020, 16'h0, 16'h0, 16'hB901, 16'h4404, 16'h00FE, 16'h0, 0, cyc);
        chk_modes("R10", 0, 1);

        // R10: vendor A, other revision
        exp_q.push_back('{5'd16, 16'h1005});
        exp_q.push_back('{5'd25, 16'hF013});
        run_case(0, 1000000, 16'h0000, 16'h0, 16'h0, 16'hB905, 16'h4404, 16'h0010, 16'h0, 0, cyc);
        chk_modes("R10", 0, 1);

        // R11: other vendor in the family
        exp_q.push_back('{5'd16, 16'h0005});
        exp_q.push_back('{5'd25, 16'h1202});
        run_case(0, 1000000, 16'h0000, 16'h0, 16'h0, 16'hB90A, 16'h4405, 16'h0, 16'h12FF, 0, cyc);
        chk_modes("R11", 0, 1);

        // R12 and R5: start while busy is ignored; modes cleared by new start
        exp_q.push_back('{5'd0, 16'h0000});
        run_case(1, 1, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1, cyc);
        chk_modes("R5", 0, 0);
        begin
            int extra = 0;
            for (int k = 0; k < 400; k++) begin
                @(negedge clk);
                if (done || busy) extra++;
            end
            chk("R12", "no second sequence from busy start", extra, 0);
            chk("R12", "modes held after done", {29'd0, store_fwd, full_duplex, alt_phy_sel}, 32'd4);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule